// File: doc/BRIEF.md
# AES3 Subframe Biphase-Mark Encoder

This block serialises one stereo channel pair onto a two-wire differential line in the professional/consumer digital audio format. For every subframe it takes a 24-bit two's-complement sample and its validity, user and channel-status bits from a one-word holding register filled through a valid/ready handshake. It adds even parity and puts a sync preamble in front of the word. It then biphase-mark encodes the 32-bit result, one line state per cycle of a state-rate clock enable (two states per bit, 128 per frame).

The block keeps its own position: state within the subframe, channel A or B, and frame within a 192-frame block. The position picks the preamble (block start, channel A, channel B) and drives a block-start flag. A timing-reset input restarts the position counters and holds the line at a fixed idle pattern. A mute input forces both line wires low while encoding carries on underneath. If no word is waiting when a subframe begins, the block sends a defined silent, invalid word and raises an underflow pulse.

Top module: `aes3_tx_encoder`

## Requirements
- R1: After rst_ni is asserted the outputs are txp_o=0, txn_o=1, blk_start_o=0, word_ready_o=1 and underflow_o=0.
- R2: Line bit n of a subframe (0..31, bits 0..3 being the preamble slot) carries sample bit n-4 for n=4..27 (bit 27 is the sample MSB), the validity flag at 28, the user bit at 29 and the channel-status bit at 30.
- R3: Line bit 31 is even parity, so bits 4..31 together hold an even number of ones.
- R4: Each data bit takes two consecutive states. The first is the inverse of the state before it, and the second toggles again for a 1 and repeats for a 0.
- R5: Channel A of frame 0 uses the block preamble, channel A of every other frame uses the A preamble, and every channel B subframe uses the B preamble.
- R6: With a preceding state of 0 the eight preamble states are 11101000 (block), 11100010 (A) and 11100100 (B), sent left to right. With a preceding state of 1 their complements are sent.
- R7: Frames are counted 0..191 and wrap, so the block preamble recurs every 192 frames.
- R8: blk_start_o rises with the fifth state of the channel B subframe of frame 0 (two bit times into it) and falls at the same point of frame 32.
- R9: word_ready_o is high exactly when the one-word holding register is empty. A word is accepted on a clock with word_valid_i and word_ready_o high, and is consumed when the next subframe begins.
- R10: If the holding register is empty when a subframe begins, that subframe carries sample 0, validity 1, user 0 and channel status 0, and underflow_o is high for one clock.
- R11: While timing_rst_i is high (and mute_i low), txp_o=1, txn_o=0 and blk_start_o=1. Afterwards encoding restarts at frame 0, channel A, with a preceding state of 0.
- R12: While mute_i is high, txp_o and txn_o are both 0, overriding timing reset. Encoding and block timing continue unchanged.
- R13: Outside the mute and timing-reset overrides, txn_o is the complement of txp_o.
- R14: On clocks with sym_en_i low the line state, position and block flag do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sym_en_i | input | 1 | State-rate enable, one line state per high cycle |
| timing_rst_i | input | 1 | Restart position counters, idle line pattern |
| mute_i | input | 1 | Drive both line wires low |
| word_valid_i | input | 1 | Subframe word offered |
| word_ready_o | output | 1 | Holding register empty |
| sample_i | input | 24 | Two's-complement audio sample |
| valid_flag_i | input | 1 | Validity flag (1 = unreliable) |
| user_i | input | 1 | User data bit |
| chan_stat_i | input | 1 | Channel-status bit |
| underflow_o | output | 1 | One-clock pulse when a subframe starts without a word |
| txp_o | output | 1 | Line positive wire |
| txn_o | output | 1 | Line negative wire |
| blk_start_o | output | 1 | Block-start flag |

## Verification
The tightest collision is a word arriving on the same clock that a subframe begins while the holding register is empty. The subframe must then go out as the underflow word, and the arriving word must stay held for the following subframe. The bench provokes this in a window where it raises word_valid_i only on the clock its model predicts as a subframe start. It judges the result through underflow_o, word_ready_o and the encoded line states of both subframes. Mute is also overlapped with timing reset, and the line levels show which one wins.

// File: rtl/aes3_pkg.sv
package aes3_pkg;
  localparam int SAMPLE_W   = 24;
  localparam int SUB_STATES = 64;
  localparam int PRE_STATES = 8;

  typedef enum logic [1:0] {PRE_BLK, PRE_CHA, PRE_CHB} pre_e;

  typedef struct packed {
    logic                par;
    logic                cs;
    logic                usr;
    logic                vld;
    logic [SAMPLE_W-1:0] smp;
  } sub_word_t;

  // state patterns for a preceding state of 0, sent MSB first
  function automatic logic [7:0] pre_bits(pre_e t);
    case (t)
      PRE_BLK: return 8'b1110_1000;
      PRE_CHA: return 8'b1110_0010;
      default: return 8'b1110_0100;
    endcase
  endfunction
endpackage

// File: rtl/aes3_word_buf.sv
module aes3_word_buf
  import aes3_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic                vld_i,
  input  logic                usr_i,
  input  logic                cs_i,
  input  logic                take_i,
  output logic                ready_o,
  output sub_word_t           word_o,
  output logic                uf_o
);
  localparam sub_word_t FILL_WORD = '{par: 1'b1, cs: 1'b0, usr: 1'b0, vld: 1'b1, smp: '0};

  logic      full_q;
  sub_word_t hold_q;
  logic      uf_q;
  logic      accept;

  assign ready_o = ~full_q;
  assign accept  = valid_i & ~full_q;
  assign word_o  = full_q ? hold_q : FILL_WORD;
  assign uf_o    = uf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      hold_q <= FILL_WORD;
      uf_q   <= 1'b0;
    end else begin
      uf_q <= take_i & ~full_q;
      if (accept) begin
        full_q     <= 1'b1;
        hold_q.smp <= smp_i;
        hold_q.vld <= vld_i;
        hold_q.usr <= usr_i;
        hold_q.cs  <= cs_i;
        hold_q.par <= ^{cs_i, usr_i, vld_i, smp_i};
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assert_accept_fills_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> full_q);
  assert_uf_only_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |-> $past(!full_q));
endmodule

// File: rtl/aes3_frame_ctr.sv
module aes3_frame_ctr
  import aes3_pkg::*;
#(
  parameter int FRAMES     = 192,
  parameter int BLK_FRAMES = 32,
  parameter int BLK_DLY    = 2,
  localparam int FRAME_W   = $clog2(FRAMES),
  localparam int ST_W      = $clog2(SUB_STATES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  input  logic               clr_i,
  output logic [ST_W-1:0]    st_o,
  output logic               sub_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               blk_o
);
  localparam logic [ST_W-1:0]    BLK_ST   = ST_W'(2 * BLK_DLY);
  localparam logic [ST_W-1:0]    ST_LAST  = ST_W'(SUB_STATES - 1);
  localparam logic [FRAME_W-1:0] FR_LAST  = FRAME_W'(FRAMES - 1);
  localparam logic [FRAME_W-1:0] FR_BLKLO = FRAME_W'(BLK_FRAMES);

  logic [ST_W-1:0]    st_q;
  logic               sub_q;
  logic [FRAME_W-1:0] frame_q;
  logic               blk_q;
  logic               at_blk_pt;

  assign at_blk_pt = sub_q & (st_q == BLK_ST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0; sub_q <= 1'b0; frame_q <= '0; blk_q <= 1'b0;
    end else if (clr_i) begin
      st_q <= '0; sub_q <= 1'b0; frame_q <= '0; blk_q <= 1'b0;
    end else if (adv_i) begin
      if (at_blk_pt && frame_q == '0)          blk_q <= 1'b1;
      else if (at_blk_pt && frame_q == FR_BLKLO) blk_q <= 1'b0;
      st_q <= st_q + 1'b1;
      if (st_q == ST_LAST) begin
        sub_q <= ~sub_q;
        if (sub_q) frame_q <= (frame_q == FR_LAST) ? '0 : frame_q + 1'b1;
      end
    end
  end

  assign st_o    = st_q;
  assign sub_o   = sub_q;
  assign frame_o = frame_q;
  assign blk_o   = blk_q;

  assert_frame_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_q <= FR_LAST);
  assert_blk_rise_pos_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blk_q) |-> (frame_q == '0 && sub_q && st_q == BLK_ST + 1'b1));
endmodule

// File: rtl/aes3_bmc.sv
module aes3_bmc
  import aes3_pkg::*;
#(
  localparam int ST_W = $clog2(SUB_STATES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            clr_i,
  input  logic [ST_W-1:0] st_i,
  input  logic            sub_i,
  input  logic            frame0_i,
  input  sub_word_t       word_i,
  output logic            lvl_o
);
  sub_word_t  cur_q;
  logic       lvl_q;
  logic       pol_q;
  pre_e       ptype;
  logic [7:0] pat;
  logic       ref_pol;
  logic       pre_state;
  logic [31:0] line_bits;
  logic       data_bit;
  logic       lvl_d;

  assign ptype     = sub_i ? PRE_CHB : (frame0_i ? PRE_BLK : PRE_CHA);
  assign pat       = pre_bits(ptype);
  assign ref_pol   = (st_i == '0) ? lvl_q : pol_q;
  assign pre_state = pat[3'd7 - st_i[2:0]] ^ ref_pol;
  assign line_bits = {cur_q, 4'b0000};
  assign data_bit  = line_bits[st_i[ST_W-1:1]];

  always_comb begin
    if (st_i < ST_W'(PRE_STATES)) lvl_d = pre_state;
    else if (st_i[0])             lvl_d = lvl_q ^ data_bit;
    else                          lvl_d = ~lvl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      pol_q <= 1'b0;
      cur_q <= '0;
    end else if (clr_i) begin
      lvl_q <= 1'b0;
      pol_q <= 1'b0;
    end else if (adv_i) begin
      lvl_q <= lvl_d;
      if (st_i == '0) begin
        pol_q <= lvl_q;
        cur_q <= word_i;
      end
    end
  end

  assign lvl_o = lvl_q;

  assert_cell_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && st_i >= ST_W'(PRE_STATES) && !st_i[0]) |=> (lvl_q != $past(lvl_q)));
  assert_pre_returns_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && st_i == ST_W'(PRE_STATES - 1)) |=> (lvl_q == pol_q));
endmodule

// File: rtl/aes3_tx_encoder.sv
module aes3_tx_encoder
  import aes3_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192,
  parameter int BLK_HI_FRAMES    = 32,
  parameter int BLK_DELAY_BITS   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sym_en_i,
  input  logic                timing_rst_i,
  input  logic                mute_i,
  input  logic                word_valid_i,
  output logic                word_ready_o,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                valid_flag_i,
  input  logic                user_i,
  input  logic                chan_stat_i,
  output logic                underflow_o,
  output logic                txp_o,
  output logic                txn_o,
  output logic                blk_start_o
);
  localparam int ST_W    = $clog2(SUB_STATES);
  localparam int FRAME_W = $clog2(FRAMES_PER_BLOCK);

  logic               adv;
  logic [ST_W-1:0]    st;
  logic               sub;
  logic [FRAME_W-1:0] frame;
  logic               blk;
  logic               take;
  sub_word_t          word;
  logic               lvl;

  assign adv  = sym_en_i & ~timing_rst_i;
  assign take = adv & (st == '0);

  aes3_word_buf u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (word_valid_i),
    .smp_i   (sample_i),
    .vld_i   (valid_flag_i),
    .usr_i   (user_i),
    .cs_i    (chan_stat_i),
    .take_i  (take),
    .ready_o (word_ready_o),
    .word_o  (word),
    .uf_o    (underflow_o)
  );

  aes3_frame_ctr #(
    .FRAMES     (FRAMES_PER_BLOCK),
    .BLK_FRAMES (BLK_HI_FRAMES),
    .BLK_DLY    (BLK_DELAY_BITS)
  ) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv),
    .clr_i   (timing_rst_i),
    .st_o    (st),
    .sub_o   (sub),
    .frame_o (frame),
    .blk_o   (blk)
  );

  aes3_bmc u_bmc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (adv),
    .clr_i    (timing_rst_i),
    .st_i     (st),
    .sub_i    (sub),
    .frame0_i (frame == '0),
    .word_i   (word),
    .lvl_o    (lvl)
  );

  // mute wins over timing reset
  always_comb begin
    if (mute_i) begin
      txp_o = 1'b0; txn_o = 1'b0;
    end else if (timing_rst_i) begin
      txp_o = 1'b1; txn_o = 1'b0;
    end else begin
      txp_o = lvl;  txn_o = ~lvl;
    end
  end

  assign blk_start_o = timing_rst_i | blk;
endmodule

// File: tb/aes3_tx_encoder_tb.sv
module aes3_tx_encoder_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sym_en = 0, trst = 0, mute = 0, wvalid = 0;
  logic [23:0] smp = '0;
  logic vf = 0, uu = 0, cc = 0;
  logic ready, uf, txp, txn, blk;

  int n_run = 0, n_fail = 0;
  bit run_chk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aes3_tx_encoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sym_en_i(sym_en), .timing_rst_i(trst), .mute_i(mute),
    .word_valid_i(wvalid), .word_ready_o(ready), .sample_i(smp), .valid_flag_i(vf),
    .user_i(uu), .chan_stat_i(cc), .underflow_o(uf), .txp_o(txp), .txn_o(txn),
    .blk_start_o(blk)
  );

  // behavioural reference
  int m_st, m_sub, m_frame, l_st, l_sub, l_frame;
  bit m_lvl, m_pol, m_blk, m_full, m_uf;
  bit [31:0] m_cur;
  bit [23:0] h_smp;
  bit h_v, h_u, h_c;

  function automatic bit [7:0] pat_of(int sub, int frame);
    if (sub == 1) return 8'b11100100;
    if (frame == 0) return 8'b11101000;
    return 8'b11100010;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_sub = 0; m_frame = 0; m_lvl = 0; m_pol = 0; m_blk = 0;
      m_full = 0; m_uf = 0; m_cur = '0; l_st = -1; l_sub = 0; l_frame = 0;
    end else begin
      bit take, was_full;
      take = sym_en && !trst && m_st == 0;
      was_full = m_full;
      m_uf = 0;
      if (take) begin
        if (was_full) begin
          m_cur = '0;
          m_cur[27:4] = h_smp; m_cur[28] = h_v; m_cur[29] = h_u; m_cur[30] = h_c;
        end else begin
          m_cur = '0; m_cur[28] = 1; m_uf = 1;
        end
        m_cur[31] = ^m_cur[30:4];
      end
      if (wvalid && !was_full) begin
        h_smp = smp; h_v = vf; h_u = uu; h_c = cc; m_full = 1;
      end else if (take) m_full = 0;
      if (trst) begin
        m_st = 0; m_sub = 0; m_frame = 0; m_lvl = 0; m_pol = 0; m_blk = 0;
      end else if (sym_en) begin
        if (m_st == 0) m_pol = m_lvl;
        if (m_st < 8) m_lvl = pat_of(m_sub, m_frame)[7 - m_st] ^ m_pol;
        else if (m_st % 2 == 0) m_lvl = !m_lvl;
        else m_lvl = m_lvl ^ m_cur[m_st / 2];
        if (m_sub == 1 && m_st == 4 && m_frame == 0) m_blk = 1;
        if (m_sub == 1 && m_st == 4 && m_frame == 32) m_blk = 0;
        l_st = m_st; l_sub = m_sub; l_frame = m_frame;
        m_st++;
        if (m_st == 64) begin
          m_st = 0;
          if (m_sub == 1) begin m_sub = 0; m_frame = (m_frame + 1) % 192; end
          else m_sub = 1;
        end
      end
    end
  end

  function automatic string line_tag();
    if (mute) return "R12";
    if (trst) return "R11";
    if (l_st < 0) return "R1";
    if (l_st < 8) return (l_frame == 0 && l_sub == 0) ? "R7" : "R5/R6";
    if (l_st / 2 == 31) return "R3";
    return "R2/R4";
  endfunction

  task automatic chk(string tag, logic act, logic exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (run_chk && rst_n) begin
      bit ep, en, eb;
      ep = mute ? 1'b0 : (trst ? 1'b1 : m_lvl);
      en = mute ? 1'b0 : (trst ? 1'b0 : !m_lvl);
      eb = trst ? 1'b1 : m_blk;
      chk(line_tag(), txp, ep, "txp");
      chk((mute || trst) ? line_tag() : "R13", txn, en, "txn");
      chk(trst ? "R11" : "R8", blk, eb, "blk_start");
      chk("R9", ready, !m_full, "word_ready");
      chk("R10", uf, m_uf, "underflow");
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic held;
    held = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", txp, 1'b0, "txp"); chk("R1", txn, 1'b1, "txn");
    chk("R1", blk, 1'b0, "blk_start"); chk("R1", ready, 1'b1, "word_ready");
    chk("R1", uf, 1'b0, "underflow");
    rst_n = 1; run_chk = 1;
    for (int cyc = 0; cyc < 60000; cyc++) begin
      @(negedge clk);
      if (cyc == 9001) held = txp;
      if (cyc >= 9002 && cyc <= 9007) chk("R14", txp, held, "txp held with enable low");
      sym_en = ($urandom % 3) != 0;
      if (cyc >= 9000 && cyc <= 9007) sym_en = 0;
      smp = 24'($urandom); vf = 1'($urandom); uu = 1'($urandom); cc = 1'($urandom);
      if (cyc >= 3000 && cyc < 3600) wvalid = 0;
      else if (cyc >= 3600 && cyc < 4800) wvalid = sym_en && !trst && m_st == 0;
      else wvalid = ($urandom % 10) < 7;
      mute = (cyc >= 5000 && cyc < 5300);
      trst = (cyc >= 5100 && cyc < 5103) || (cyc >= 8000 && cyc < 8003);
    end
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule